// File: doc/BRIEF.md
# Configuration Image Store and Replay Engine

This block holds the full register image for every front-end chip behind every hub in a single on-chip RAM. Software loads the image once. A reset-style trigger, such as a hard-reset command, then sends the stored image out to the chips with no software involvement. Software can reach the RAM in two ways. The first is an indirect pair: an address register that selects a word and a value register that reads or writes that word. The second is a linear window, in which window offset k is RAM word k, so consecutive block transfers work directly.

The replay engine walks the image in a fixed order and issues one chip-register write at a time on a request port that carries hub, chip, local address and data. It holds each request until that request is acknowledged. The image for each chip is laid out in RAM as 145 consecutive words: 128 channel words followed by 17 general words. The chip for hub h and chip c starts at word (h*CHIPS_PER_HUB + c)*145. A per-hub enable mask removes whole hubs from a replay. The sizes are parameters. In the intended system there are 24 chips per hub and up to 12 hubs.

Top module: `cfg_blaster`

## Requirements
- R1: Software access kinds are selected by `sw_kind`: 0 is the address register, 1 is the value register, 2 is the window and 3 is reserved. A kind-0 write loads the address register from the low bits of `sw_wdata`, and a kind-0 read returns it zero-extended. A kind-1 write stores `sw_wdata` at the word the address register selects, and a kind-1 read returns that word. The address register never advances on its own.
- R2: A kind-2 access at `sw_offset` k reads or writes RAM word k. It reaches the same storage as the indirect pair.
- R3: A kind-1 or kind-2 access whose target word is at or beyond the image depth answers with `sw_err` set and stores nothing. Kind 3 always answers with `sw_err` set.
- R4: Every request on `sw_req` is answered by `sw_ack` exactly one cycle later, and `sw_ack` is never raised otherwise. `sw_rdata` is zero for every answer that is not a successful read.
- R5: `replay_trig` while idle starts a replay. `replay_trig` while a replay runs has no effect.
- R6: A replay issues writes for hubs in ascending order. Within a hub it goes through chips in ascending order. Within a chip it uses local addresses 0x00 to 0x7F and then 0x81 to 0x91. Each write carries the matching RAM word: word w of chip c on hub h is at (h*CHIPS_PER_HUB + c)*145 + w.
- R7: Only one write is outstanding at a time. A request stays asserted with hub, chip, address and data unchanged until `wr_ack`.
- R8: Hubs whose `hub_enable` bit is 0 get no writes. With no hub enabled, a replay ends with `done` and no writes.
- R9: `busy` is high from the cycle after an accepted trigger through the cycle of `done`. While `busy` is high, every kind-1 or kind-2 access is refused with `sw_err` and leaves the RAM unchanged. Kind-0 accesses are still served.
- R10: `done` is a single-cycle pulse, once per replay. It is raised after the last write of the last enabled hub has been acknowledged.
- R11: A write acknowledged with `wr_err` sets `err_flag`, and `err_hub`/`err_chip` record the first failing write. The flag and the recorded indices hold until the next accepted trigger clears them. The replay continues after an error.
- R12: A RAM write accepted in the same cycle as a trigger, while idle, is part of the image that this replay sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | Software access request, one cycle |
| sw_wr | input | 1 | 1 = write, 0 = read |
| sw_kind | input | 2 | 0 address register, 1 value register, 2 window, 3 reserved |
| sw_offset | input | AW (11) | Window word offset |
| sw_wdata | input | 32 | Write data |
| sw_ack | output | 1 | Answer strobe, one cycle after request |
| sw_err | output | 1 | Access refused |
| sw_rdata | output | 32 | Read data |
| replay_trig | input | 1 | Reset-style replay trigger |
| hub_enable | input | NUM_HUBS (4) | Hubs included in a replay |
| busy | output | 1 | Replay in progress |
| done | output | 1 | Replay finished pulse |
| wr_valid | output | 1 | Chip write request |
| wr_hub | output | HUB_W (2) | Hub index of request |
| wr_chip | output | CHIP_W (1) | Chip index of request |
| wr_laddr | output | 8 | Local register address |
| wr_data | output | 32 | Register value |
| wr_ack | input | 1 | Request completed |
| wr_err | input | 1 | Completion carried an error |
| err_flag | output | 1 | Sticky replay error |
| err_hub | output | HUB_W (2) | Hub of first failing write |
| err_chip | output | CHIP_W (1) | Chip of first failing write |

## Verification
A software RAM write and a replay trigger can land in the same cycle. The bench drives both on one edge: a window write to word 0 together with the trigger. The first write sent to the chip link must then carry the new word. Software traffic and a second trigger are also injected while a replay is in flight. The reference model predicts the refusals, the unchanged RAM contents and the unbroken write order that must follow.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_SEEK,
    ENG_FETCH,
    ENG_ISSUE,
    ENG_FINISH
  } eng_state_t;

  typedef enum logic [1:0] {
    SW_ADDR   = 2'd0,
    SW_VALUE  = 2'd1,
    SW_WINDOW = 2'd2,
    SW_RSVD   = 2'd3
  } sw_kind_t;
endpackage

// File: rtl/cfgb_ram.sv
module cfgb_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1160,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= store[raddr];
    end
  end
endmodule

// File: rtl/cfgb_sw_port.sv
module cfgb_sw_port
  import cfgb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1160,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req,
  input  logic              sw_wr,
  input  logic [1:0]        sw_kind,
  input  logic [AW-1:0]     sw_offset,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] ram_q,
  output logic              sw_ack,
  output logic              sw_err,
  output logic [DATA_W-1:0] sw_rdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic [AW-1:0]     ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);
  logic [AW-1:0]     addr_q;
  logic              addr_we;
  logic              is_mem;
  logic              in_range;
  logic              mem_ok;
  logic              err_d;
  logic [DATA_W-1:0] rdata_d;
  logic              ack_q;
  logic              err_q;
  logic              from_ram_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    is_mem    = (sw_kind == SW_VALUE) || (sw_kind == SW_WINDOW);
    ram_addr  = (sw_kind == SW_VALUE) ? addr_q : sw_offset;
    in_range  = 32'(ram_addr) < DEPTH;
    mem_ok    = sw_req && is_mem && !busy && in_range;
    ram_we    = mem_ok && sw_wr;
    ram_re    = mem_ok && !sw_wr;
    ram_wdata = sw_wdata;
    addr_we   = sw_req && (sw_kind == SW_ADDR) && sw_wr;
    err_d     = sw_req && ((sw_kind == SW_RSVD) || (is_mem && (busy || !in_range)));
    rdata_d   = '0;
    if (sw_req && (sw_kind == SW_ADDR) && !sw_wr) begin
      rdata_d = {{(DATA_W-AW){1'b0}}, addr_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_we) begin
      addr_q <= sw_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q      <= 1'b0;
      err_q      <= 1'b0;
      from_ram_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      ack_q      <= sw_req;
      err_q      <= err_d;
      from_ram_q <= ram_re;
      rdata_q    <= rdata_d;
    end
  end

  assign sw_ack   = ack_q;
  assign sw_err   = err_q;
  assign sw_rdata = from_ram_q ? ram_q : rdata_q;
endmodule

// File: rtl/cfgb_replay.sv
module cfgb_replay
  import cfgb_pkg::*;
#(
  parameter int NUM_HUBS  = 4,
  parameter int CHIPS     = 2,
  parameter int CHAN_REGS = 128,
  parameter int GEN_REGS  = 17,
  parameter int GEN_BASE  = 129,
  parameter int DATA_W    = 32,
  parameter int LADDR_W   = 8,
  parameter int AW        = 11,
  parameter int HUB_W     = 2,
  parameter int CHIP_W    = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig,
  input  logic [NUM_HUBS-1:0] hub_en,
  input  logic [DATA_W-1:0]   ram_q,
  output logic                ram_re,
  output logic [AW-1:0]       ram_raddr,
  output logic                busy,
  output logic                done,
  output logic                wr_valid,
  output logic [HUB_W-1:0]    wr_hub,
  output logic [CHIP_W-1:0]   wr_chip,
  output logic [LADDR_W-1:0]  wr_laddr,
  output logic [DATA_W-1:0]   wr_data,
  input  logic                wr_ack,
  input  logic                wr_err,
  output logic                err_flag,
  output logic [HUB_W-1:0]    err_hub,
  output logic [CHIP_W-1:0]   err_chip
);
  localparam int WORDS  = CHAN_REGS + GEN_REGS;
  localparam int WORD_W = $clog2(WORDS);
  localparam int HC_W   = $clog2(NUM_HUBS + 1);

  eng_state_t        state_q, state_d;
  logic [HC_W-1:0]   hub_q, hub_d;
  logic [CHIP_W-1:0] chip_q, chip_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              eflag_q, eflag_d;
  logic [HUB_W-1:0]  ehub_q, ehub_d;
  logic [CHIP_W-1:0] echip_q, echip_d;
  logic              hub_end, hub_on, last_word, last_chip;

  always_comb begin
    hub_end   = 32'(hub_q) == NUM_HUBS;
    hub_on    = !hub_end && hub_en[hub_q[HUB_W-1:0]];
    last_word = 32'(word_q) == WORDS - 1;
    last_chip = 32'(chip_q) == CHIPS - 1;
  end

  always_comb begin
    state_d = state_q;
    hub_d   = hub_q;
    chip_d  = chip_q;
    word_d  = word_q;
    eflag_d = eflag_q;
    ehub_d  = ehub_q;
    echip_d = echip_q;
    case (state_q)
      ENG_IDLE: begin
        if (trig) begin
          state_d = ENG_SEEK;
          hub_d   = '0;
          chip_d  = '0;
          word_d  = '0;
          eflag_d = 1'b0;
          ehub_d  = '0;
          echip_d = '0;
        end
      end
      ENG_SEEK: begin
        if (hub_end) begin
          state_d = ENG_FINISH;
        end else if (hub_on) begin
          state_d = ENG_FETCH;
        end else begin
          hub_d = hub_q + 1'b1;
        end
      end
      ENG_FETCH: state_d = ENG_ISSUE;
      ENG_ISSUE: begin
        if (wr_ack) begin
          if (wr_err && !eflag_q) begin
            eflag_d = 1'b1;
            ehub_d  = hub_q[HUB_W-1:0];
            echip_d = chip_q;
          end
          if (!last_word) begin
            word_d  = word_q + 1'b1;
            state_d = ENG_FETCH;
          end else begin
            word_d = '0;
            if (!last_chip) begin
              chip_d  = chip_q + 1'b1;
              state_d = ENG_FETCH;
            end else begin
              chip_d  = '0;
              hub_d   = hub_q + 1'b1;
              state_d = ENG_SEEK;
            end
          end
        end
      end
      ENG_FINISH: state_d = ENG_IDLE;
      default:    state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      hub_q   <= '0;
      chip_q  <= '0;
      word_q  <= '0;
      eflag_q <= 1'b0;
      ehub_q  <= '0;
      echip_q <= '0;
    end else begin
      state_q <= state_d;
      hub_q   <= hub_d;
      chip_q  <= chip_d;
      word_q  <= word_d;
      eflag_q <= eflag_d;
      ehub_q  <= ehub_d;
      echip_q <= echip_d;
    end
  end

  always_comb begin
    ram_re    = state_q == ENG_FETCH;
    ram_raddr = AW'((32'(hub_q) * CHIPS + 32'(chip_q)) * WORDS + 32'(word_q));
    busy      = state_q != ENG_IDLE;
    done      = state_q == ENG_FINISH;
    wr_valid  = state_q == ENG_ISSUE;
    wr_hub    = hub_q[HUB_W-1:0];
    wr_chip   = chip_q;
    wr_data   = ram_q;
    if (32'(word_q) < CHAN_REGS) begin
      wr_laddr = LADDR_W'(word_q);
    end else begin
      wr_laddr = LADDR_W'(32'(word_q) - CHAN_REGS + GEN_BASE);
    end
  end

  assign err_flag = eflag_q;
  assign err_hub  = ehub_q;
  assign err_chip = echip_q;
endmodule

// File: rtl/cfg_blaster.sv
module cfg_blaster #(
  parameter int NUM_HUBS  = 4,
  parameter int CHIPS     = 2,
  parameter int CHAN_REGS = 128,
  parameter int GEN_REGS  = 17,
  parameter int GEN_BASE  = 129,
  parameter int DATA_W    = 32,
  parameter int LADDR_W   = 8,
  localparam int DEPTH    = NUM_HUBS * CHIPS * (CHAN_REGS + GEN_REGS),
  localparam int AW       = $clog2(DEPTH),
  localparam int HUB_W    = (NUM_HUBS > 1) ? $clog2(NUM_HUBS) : 1,
  localparam int CHIP_W   = (CHIPS > 1) ? $clog2(CHIPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_req,
  input  logic                sw_wr,
  input  logic [1:0]          sw_kind,
  input  logic [AW-1:0]       sw_offset,
  input  logic [DATA_W-1:0]   sw_wdata,
  output logic                sw_ack,
  output logic                sw_err,
  output logic [DATA_W-1:0]   sw_rdata,
  input  logic                replay_trig,
  input  logic [NUM_HUBS-1:0] hub_enable,
  output logic                busy,
  output logic                done,
  output logic                wr_valid,
  output logic [HUB_W-1:0]    wr_hub,
  output logic [CHIP_W-1:0]   wr_chip,
  output logic [LADDR_W-1:0]  wr_laddr,
  output logic [DATA_W-1:0]   wr_data,
  input  logic                wr_ack,
  input  logic                wr_err,
  output logic                err_flag,
  output logic [HUB_W-1:0]    err_hub,
  output logic [CHIP_W-1:0]   err_chip
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              sw_we, sw_re, eng_re;
  logic [AW-1:0]     sw_addr, eng_addr, rd_addr;
  logic [DATA_W-1:0] sw_wd, ram_q;
  logic              rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign rd_en   = eng_re | sw_re;
  assign rd_addr = eng_re ? eng_addr : sw_addr;

  cfgb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (sw_we),
    .waddr (sw_addr),
    .wdata (sw_wd),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (ram_q)
  );

  cfgb_sw_port #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_sw (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sw_req    (sw_req),
    .sw_wr     (sw_wr),
    .sw_kind   (sw_kind),
    .sw_offset (sw_offset),
    .sw_wdata  (sw_wdata),
    .busy      (busy),
    .ram_q     (ram_q),
    .sw_ack    (sw_ack),
    .sw_err    (sw_err),
    .sw_rdata  (sw_rdata),
    .ram_we    (sw_we),
    .ram_re    (sw_re),
    .ram_addr  (sw_addr),
    .ram_wdata (sw_wd)
  );

  cfgb_replay #(
    .NUM_HUBS (NUM_HUBS), .CHIPS (CHIPS), .CHAN_REGS (CHAN_REGS),
    .GEN_REGS (GEN_REGS), .GEN_BASE (GEN_BASE), .DATA_W (DATA_W),
    .LADDR_W (LADDR_W), .AW (AW), .HUB_W (HUB_W), .CHIP_W (CHIP_W)
  ) u_replay (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .trig      (replay_trig),
    .hub_en    (hub_enable),
    .ram_q     (ram_q),
    .ram_re    (eng_re),
    .ram_raddr (eng_addr),
    .busy      (busy),
    .done      (done),
    .wr_valid  (wr_valid),
    .wr_hub    (wr_hub),
    .wr_chip   (wr_chip),
    .wr_laddr  (wr_laddr),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .wr_err    (wr_err),
    .err_flag  (err_flag),
    .err_hub   (err_hub),
    .err_chip  (err_chip)
  );
endmodule

// File: rtl/cfg_blaster_chk.sv
module cfg_blaster_chk #(
  parameter int NUM_HUBS  = 4,
  parameter int CHAN_REGS = 128,
  parameter int GEN_REGS  = 17,
  parameter int GEN_BASE  = 129,
  parameter int DATA_W    = 32,
  parameter int LADDR_W   = 8,
  parameter int HUB_W     = 2,
  parameter int CHIP_W    = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sw_req,
  input logic [1:0]          sw_kind,
  input logic                sw_ack,
  input logic                sw_err,
  input logic                replay_trig,
  input logic [NUM_HUBS-1:0] hub_enable,
  input logic                busy,
  input logic                done,
  input logic                wr_valid,
  input logic [HUB_W-1:0]    wr_hub,
  input logic [CHIP_W-1:0]   wr_chip,
  input logic [LADDR_W-1:0]  wr_laddr,
  input logic [DATA_W-1:0]   wr_data,
  input logic                wr_ack,
  input logic                err_flag,
  input logic [HUB_W-1:0]    err_hub,
  input logic [CHIP_W-1:0]   err_chip
);
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ack |=> wr_valid && $stable(wr_hub) && $stable(wr_chip)
                            && $stable(wr_laddr) && $stable(wr_data));

  p_laddr_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (32'(wr_laddr) < CHAN_REGS)
                 || (32'(wr_laddr) >= GEN_BASE && 32'(wr_laddr) < GEN_BASE + GEN_REGS));

  p_hub_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> hub_enable[wr_hub]);

  p_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> sw_ack);

  p_no_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_req |=> !sw_ack);

  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sw_req && (sw_kind == 2'd1 || sw_kind == 2'd2) |=> sw_err);

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && replay_trig |=> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !(replay_trig && !busy) |=> err_flag && $stable(err_hub) && $stable(err_chip));
endmodule

bind cfg_blaster cfg_blaster_chk #(
  .NUM_HUBS (NUM_HUBS), .CHAN_REGS (CHAN_REGS), .GEN_REGS (GEN_REGS),
  .GEN_BASE (GEN_BASE), .DATA_W (DATA_W), .LADDR_W (LADDR_W),
  .HUB_W (HUB_W), .CHIP_W (CHIP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sw_req      (sw_req),
  .sw_kind     (sw_kind),
  .sw_ack      (sw_ack),
  .sw_err      (sw_err),
  .replay_trig (replay_trig),
  .hub_enable  (hub_enable),
  .busy        (busy),
  .done        (done),
  .wr_valid    (wr_valid),
  .wr_hub      (wr_hub),
  .wr_chip     (wr_chip),
  .wr_laddr    (wr_laddr),
  .wr_data     (wr_data),
  .wr_ack      (wr_ack),
  .err_flag    (err_flag),
  .err_hub     (err_hub),
  .err_chip    (err_chip)
);

// File: tb/cfg_blaster_test.sv
module cfg_blaster_test;
  localparam int NH = 4, NC = 2, WPC = 145;
  localparam int DEPTH = NH * NC * WPC;
  localparam int AW = $clog2(DEPTH);

  logic clk, rst_n;
  logic sw_req, sw_wr;
  logic [1:0] sw_kind;
  logic [AW-1:0] sw_offset;
  logic [31:0] sw_wdata, sw_rdata, wr_data;
  logic sw_ack, sw_err, replay_trig, busy, done, wr_valid, wr_ack, wr_err, err_flag;
  logic [NH-1:0] hub_enable;
  logic [1:0] wr_hub, err_hub;
  logic [0:0] wr_chip, err_chip;
  logic [7:0] wr_laddr;

  cfg_blaster uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] mem [DEPTH];
  int maddr = 0;
  bit m_busy = 0;
  logic [55:0] expq[$];
  bit p_ack, p_err;
  logic [31:0] p_rdata;
  string cur_tag = "R4";
  int wait_cnt = 0, wr_idx = 0, err_at1 = -1, err_at2 = -1, done_seen = 0;
  bit x_eflag = 0;
  int x_ehub = 0, x_echip = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int k);
    return (k * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic prepare();
    int tgt;
    p_ack = sw_req; p_err = 0; p_rdata = '0;
    if (sw_req) begin
      case (sw_kind)
        2'd0: if (sw_wr) maddr = int'(sw_wdata[AW-1:0]); else p_rdata = 32'(maddr);
        2'd1, 2'd2: begin
          tgt = (sw_kind == 2'd1) ? maddr : int'(sw_offset);
          if (m_busy || tgt >= DEPTH) p_err = 1;
          else if (sw_wr) mem[tgt] = sw_wdata;
          else p_rdata = mem[tgt];
        end
        default: p_err = 1;
      endcase
    end
    if (replay_trig && !m_busy) begin
      m_busy = 1; expq.delete(); wr_idx = 0; wait_cnt = 0; done_seen = 0; x_eflag = 0;
      for (int h = 0; h < NH; h++)
        if (hub_enable[h])
          for (int c = 0; c < NC; c++)
            for (int w = 0; w < WPC; w++)
              expq.push_back({8'(h), 8'(c), 8'((w < 128) ? w : w + 1),
                              mem[(h * NC + c) * WPC + w]});
    end
  endtask

  task automatic tick();
    logic [55:0] e;
    prepare();
    @(posedge clk);
    @(negedge clk);
    sw_req = 0; replay_trig = 0; wr_ack = 0; wr_err = 0;
    chk("R4 ack", 64'(sw_ack), 64'(p_ack));
    if (p_ack) begin
      chk({cur_tag, " err"}, 64'(sw_err), 64'(p_err));
      chk({cur_tag, " rdata"}, 64'(sw_rdata), 64'(p_rdata));
    end
    chk("R9 busy", 64'(busy), 64'(m_busy));
    if (done) begin
      chk("R10 done after last write", 64'(expq.size()), 64'd0);
      done_seen++;
      m_busy = 0;
    end
    if (wr_valid) begin
      if (wait_cnt >= wr_idx % 4) begin
        wr_ack = 1;
        wr_err = (wr_idx == err_at1) || (wr_idx == err_at2);
        if (expq.size() == 0) begin
          chk("R6 unexpected write", 64'(wr_valid), 64'd0);
        end else begin
          e = expq.pop_front();
          chk("R6 write order/data", {8'(wr_hub), 8'(wr_chip), wr_laddr, wr_data}, 64'(e));
          if (wr_err && !x_eflag) begin
            x_eflag = 1; x_ehub = int'(e[55:48]); x_echip = int'(e[47:40]);
          end
        end
        wr_idx++; wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  endtask

  task automatic sw_op(logic [1:0] k, bit w, int off, logic [31:0] d, string tag);
    sw_req = 1; sw_wr = w; sw_kind = k; sw_offset = AW'(off); sw_wdata = d; cur_tag = tag;
    tick();
  endtask

  task automatic run_replay(logic [NH-1:0] mask, bit inject);
    int i;
    hub_enable = mask; replay_trig = 1;
    tick();
    i = 0;
    while (done_seen == 0 && i < 20000) begin
      if (inject && i == 10) begin
        sw_req = 1; sw_wr = 1; sw_kind = 2; sw_offset = AW'(3); sw_wdata = 32'hDEAD; cur_tag = "R9";
      end
      if (inject && i == 20) replay_trig = 1;
      if (inject && i == 30) begin
        sw_req = 1; sw_wr = 1; sw_kind = 0; sw_wdata = 32'd9; cur_tag = "R9";
      end
      if (inject && i == 40) begin
        sw_req = 1; sw_wr = 0; sw_kind = 1; cur_tag = "R9";
      end
      tick();
      i++;
    end
    tick();
    chk("R10 one done", 64'(done_seen), 64'd1);
    chk("R6 all writes sent", 64'(expq.size()), 64'd0);
    chk("R11 err_flag", 64'(err_flag), 64'(x_eflag));
    if (x_eflag) begin
      chk("R11 err_hub", 64'(err_hub), 64'(x_ehub));
      chk("R11 err_chip", 64'(err_chip), 64'(x_echip));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) mem[k] = '0;
    rst_n = 0; sw_req = 0; sw_wr = 0; sw_kind = 0; sw_offset = '0; sw_wdata = '0;
    replay_trig = 0; hub_enable = '0; wr_ack = 0; wr_err = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset busy", 64'(busy), 64'd0);
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R7 reset wr_valid", 64'(wr_valid), 64'd0);
    chk("R4 reset ack", 64'(sw_ack), 64'd0);
    chk("R11 reset err", 64'(err_flag), 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    sw_op(0, 1, 0, 32'd5, "R1");
    sw_op(0, 0, 0, 0, "R1");
    sw_op(1, 1, 0, 32'h1234, "R1");
    sw_op(1, 0, 0, 0, "R1");
    sw_op(1, 0, 0, 0, "R1");
    sw_op(2, 0, 5, 0, "R2");
    sw_op(2, 1, 7, 32'hCAFE, "R2");
    sw_op(0, 1, 0, 32'd7, "R1");
    sw_op(1, 0, 0, 0, "R2");
    sw_op(0, 1, 0, DEPTH, "R3");
    sw_op(1, 1, 0, 32'h1, "R3");
    sw_op(2, 1, DEPTH + 20, 32'h1, "R3");
    sw_op(2, 0, DEPTH, 0, "R3");
    sw_op(3, 0, 0, 0, "R3");
    sw_op(3, 1, 0, 0, "R3");

    for (int k = 0; k < DEPTH; k++) sw_op(2, 1, k, pat(k), "R2");
    sw_op(2, 0, DEPTH - 1, 0, "R2");

    run_replay(4'b1111, 1);
    sw_op(2, 0, 3, 0, "R9");
    sw_op(0, 0, 0, 0, "R9");

    err_at1 = 150; err_at2 = 400;
    run_replay(4'b0101, 0);
    err_at1 = -1; err_at2 = -1;

    run_replay(4'b0000, 0);
    chk("R11 cleared by trigger", 64'(err_flag), 64'd0);

    sw_req = 1; sw_wr = 1; sw_kind = 2; sw_offset = '0; sw_wdata = 32'hBEEF0001; cur_tag = "R12";
    run_replay(4'b0001, 0);
    sw_op(2, 0, 0, 0, "R12");
    run_replay(4'b1000, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule